// File: doc/BRIEF.md
# Bus Port Read/Write Line Buffer

This block sits between one single-master bus slave port and the request side of a shared SDRAM scheduler. It holds one eight-word read line and one posted write line. A read that misses asks the scheduler for the whole aligned line and keeps every returned word. Later reads anywhere in that line are answered from the buffer with no new request. Writes are posted: the bus transfer ends at once, and the bytes are gathered into a line-wide write buffer that drains to the scheduler as one masked request. A write to a line that already waits in the buffer merges into it.

Coherence is local. A write that lands in the held read line also patches the matching bytes of that line. A read that misses the read line while its line waits in the write buffer is held until the write drains, and only then fetches. The bus request is a valid/ready pair: the master holds address, direction, byte enables and write data until `bus_ready` is high at a clock edge, and read data is valid in that same cycle. Both scheduler requests are valid/ready. A read request holds its line address until accepted. A write request holds its address until accepted, but its data and byte mask may gain merged bytes while it waits, so the scheduler takes them at the handshake. The read response has no back-pressure: the scheduler delivers eight beats in ascending word order, each marked by `rd_rsp_valid`, and the block always takes them.

Top module: `bus_port_buffer`

## Requirements
- R1: After reset the read line and the write buffer are empty, and neither `rd_req_valid` nor `wr_req_valid` is high.
- R2: A read that hits neither buffer raises `rd_req_valid` on the next cycle, with `rd_req_addr` equal to the bus address with its low five bits cleared, and keeps it stable until `rd_req_ready`.
- R3: The eight response beats fill words 0 to 7 of the line in order. From the cycle after the eighth beat, the held read completes with the returned word.
- R4: A read within the held valid line completes in the cycle it is presented, returns the stored word, and raises no request.
- R5: A write completes in the cycle it is presented when the write buffer is empty or holds the same line.
- R6: Writes to one line merge byte by byte. `wr_req_be` bit 4*w+b marks byte b of word w, and `wr_req_data` bits 32*w+8*b+7 down to 32*w+8*b carry that byte. A write accepted in the cycle the buffer drains starts a new mask holding only its own bytes.
- R7: A write to another line while the write buffer is occupied keeps `bus_ready` low until the buffer has drained.
- R8: A write that falls in the valid read line updates the enabled bytes of that line, so later read hits return the new bytes.
- R9: A read that misses the read line but whose line waits in the write buffer keeps `bus_ready` low and raises no read request until that write drains.
- R10: `wr_req_valid` is high exactly while the write buffer holds data. Until accepted, its address stays stable and no mask bit falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus transfer presented |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Byte address |
| bus_be | input | DW/8 | Byte enables for writes |
| bus_wdata | input | DW | Write data |
| bus_ready | output | 1 | Transfer completes this cycle (high when idle) |
| bus_rdata | output | DW | Read data, valid with a read handshake |
| rd_req_valid | output | 1 | Line fetch request |
| rd_req_ready | input | 1 | Scheduler accepts fetch |
| rd_req_addr | output | AW | Line-aligned fetch address |
| rd_rsp_valid | input | 1 | Response beat valid |
| rd_rsp_data | input | DW | Response word |
| wr_req_valid | output | 1 | Write line pending |
| wr_req_ready | input | 1 | Scheduler accepts write line |
| wr_req_addr | output | AW | Line-aligned write address |
| wr_req_data | output | WORDS*DW | Merged write line |
| wr_req_be | output | WORDS*DW/8 | Byte mask of the write line |

## Verification
A stale or corrupted read line shows as wrong `bus_rdata` on the first hit that touches the bad word. The reference model compares every read completion against the values most recently written from the bus, so a missed patch or a misplaced fill beat is reported in that cycle. A wrong tag or valid bit shows within one cycle as a `bus_ready` that disagrees with the hit prediction, or as a spurious or missing `rd_req_valid`. Lost merge bytes in the write buffer appear at the drain handshake as a mask or data mismatch, and they reach read data after the next fetch.

// File: rtl/bpb_pkg.sv
package bpb_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_FILL = 2'd2
  } fill_state_e;
endpackage

// File: rtl/bpb_line_buf.sv
// Read line storage: filled beat by beat, patched by write hits.
module bpb_line_buf #(
  parameter int DW    = 32,
  parameter int WORDS = 8,
  parameter int TAG_W = 27
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fill_start,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic                     beat_valid,
  input  logic [DW-1:0]            beat_data,
  input  logic                     upd_en,
  input  logic [$clog2(WORDS)-1:0] upd_idx,
  input  logic [DW/8-1:0]          upd_be,
  input  logic [DW-1:0]            upd_data,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic                     line_valid,
  output logic [TAG_W-1:0]         line_tag,
  output logic [DW-1:0]            rd_data,
  output logic                     fill_last
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int BE_W  = DW / 8;

  logic [DW-1:0]    words_q [WORDS];
  logic [IDX_W-1:0] beat_cnt_q;

  assign fill_last = beat_valid && (beat_cnt_q == IDX_W'(WORDS - 1));
  assign rd_data   = words_q[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_valid <= 1'b0;
      line_tag   <= '0;
      beat_cnt_q <= '0;
    end else if (fill_start) begin
      line_valid <= 1'b0;
      line_tag   <= fill_tag;
      beat_cnt_q <= '0;
    end else if (beat_valid) begin
      beat_cnt_q <= beat_cnt_q + 1'b1;
      if (fill_last) line_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int w = 0; w < WORDS; w++) begin
      for (int b = 0; b < BE_W; b++) begin
        if (beat_valid && beat_cnt_q == IDX_W'(w))
          words_q[w][8*b +: 8] <= beat_data[8*b +: 8];
        else if (upd_en && upd_idx == IDX_W'(w) && upd_be[b])
          words_q[w][8*b +: 8] <= upd_data[8*b +: 8];
      end
    end
  end
endmodule

// File: rtl/bpb_wr_merge.sv
// Posted write line: gathers byte writes to one line until drained.
module bpb_wr_merge #(
  parameter int DW    = 32,
  parameter int WORDS = 8,
  parameter int TAG_W = 27
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [TAG_W-1:0]          wr_tag,
  input  logic [$clog2(WORDS)-1:0]  wr_idx,
  input  logic [DW/8-1:0]           wr_be,
  input  logic [DW-1:0]             wr_data,
  input  logic                      drain,
  output logic                      buf_valid,
  output logic [TAG_W-1:0]          buf_tag,
  output logic [WORDS*DW-1:0]       buf_data,
  output logic [WORDS*DW/8-1:0]     buf_be
);
  localparam int IDX_W = $clog2(WORDS);
  localparam int BE_W  = DW / 8;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_valid <= 1'b0;
      buf_tag   <= '0;
      buf_data  <= '0;
      buf_be    <= '0;
    end else if (wr_en) begin
      buf_valid <= 1'b1;
      buf_tag   <= wr_tag;
      for (int w = 0; w < WORDS; w++) begin
        for (int b = 0; b < BE_W; b++) begin
          if (wr_idx == IDX_W'(w) && wr_be[b]) begin
            buf_be[w*BE_W + b]          <= 1'b1;
            buf_data[w*DW + 8*b +: 8]   <= wr_data[8*b +: 8];
          end else if (drain) begin
            buf_be[w*BE_W + b]          <= 1'b0;
          end
        end
      end
    end else if (drain) begin
      buf_valid <= 1'b0;
      buf_be    <= '0;
    end
  end
endmodule

// File: rtl/bpb_miss_fsm.sv
// Line fetch sequencer: request, then collect the burst.
module bpb_miss_fsm
  import bpb_pkg::*;
#(
  parameter int TAG_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_go,
  input  logic [TAG_W-1:0] miss_tag,
  input  logic             req_ready,
  input  logic             fill_last,
  output logic             req_valid,
  output logic [TAG_W-1:0] req_tag,
  output logic             fill_active,
  output logic             fill_start,
  output logic             idle
);
  fill_state_e st_q;

  assign req_valid   = (st_q == FS_REQ);
  assign fill_start  = req_valid && req_ready;
  assign fill_active = (st_q == FS_FILL);
  assign idle        = (st_q == FS_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= FS_IDLE;
      req_tag <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (miss_go) begin
          st_q    <= FS_REQ;
          req_tag <= miss_tag;
        end
        FS_REQ:  if (req_ready) st_q <= FS_FILL;
        FS_FILL: if (fill_last) st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bus_port_buffer.sv
module bus_port_buffer
  import bpb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_valid,
  input  logic                   bus_write,
  input  logic [AW-1:0]          bus_addr,
  input  logic [DW/8-1:0]        bus_be,
  input  logic [DW-1:0]          bus_wdata,
  output logic                   bus_ready,
  output logic [DW-1:0]          bus_rdata,
  output logic                   rd_req_valid,
  input  logic                   rd_req_ready,
  output logic [AW-1:0]          rd_req_addr,
  input  logic                   rd_rsp_valid,
  input  logic [DW-1:0]          rd_rsp_data,
  output logic                   wr_req_valid,
  input  logic                   wr_req_ready,
  output logic [AW-1:0]          wr_req_addr,
  output logic [WORDS*DW-1:0]    wr_req_data,
  output logic [WORDS*DW/8-1:0]  wr_req_be
);
  localparam int BE_W   = DW / 8;
  localparam int IDX_W  = $clog2(WORDS);
  localparam int BYTE_W = $clog2(BE_W);
  localparam int OFF_W  = IDX_W + BYTE_W;
  localparam int TAG_W  = AW - OFF_W;

  logic [TAG_W-1:0] bus_tag, line_tag, wb_tag, req_tag;
  logic [IDX_W-1:0] bus_idx;
  logic line_valid, wb_valid, fill_last, fill_active, fill_start, fsm_idle;
  logic is_rd, is_wr, rd_hit, wb_match, wr_accept, drain, miss_go;

  assign bus_tag  = bus_addr[AW-1:OFF_W];
  assign bus_idx  = bus_addr[OFF_W-1:BYTE_W];
  assign is_rd    = bus_valid && !bus_write;
  assign is_wr    = bus_valid && bus_write;
  assign rd_hit   = line_valid && (line_tag == bus_tag);
  assign wb_match = wb_valid && (wb_tag == bus_tag);

  always_comb begin
    if (is_wr)      bus_ready = !wb_valid || wb_match;
    else if (is_rd) bus_ready = rd_hit;
    else            bus_ready = 1'b1;
  end

  assign wr_accept = is_wr && bus_ready;
  assign drain     = wb_valid && wr_req_ready;
  assign miss_go   = fsm_idle && is_rd && !rd_hit && !wb_match;

  assign rd_req_addr  = {req_tag, {OFF_W{1'b0}}};
  assign wr_req_addr  = {wb_tag, {OFF_W{1'b0}}};
  assign wr_req_valid = wb_valid;

  bpb_line_buf #(.DW(DW), .WORDS(WORDS), .TAG_W(TAG_W)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_start (fill_start),
    .fill_tag   (req_tag),
    .beat_valid (rd_rsp_valid && fill_active),
    .beat_data  (rd_rsp_data),
    .upd_en     (wr_accept && rd_hit),
    .upd_idx    (bus_idx),
    .upd_be     (bus_be),
    .upd_data   (bus_wdata),
    .rd_idx     (bus_idx),
    .line_valid (line_valid),
    .line_tag   (line_tag),
    .rd_data    (bus_rdata),
    .fill_last  (fill_last)
  );

  bpb_wr_merge #(.DW(DW), .WORDS(WORDS), .TAG_W(TAG_W)) u_wbuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_accept),
    .wr_tag    (bus_tag),
    .wr_idx    (bus_idx),
    .wr_be     (bus_be),
    .wr_data   (bus_wdata),
    .drain     (drain),
    .buf_valid (wb_valid),
    .buf_tag   (wb_tag),
    .buf_data  (wr_req_data),
    .buf_be    (wr_req_be)
  );

  bpb_miss_fsm #(.TAG_W(TAG_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_go     (miss_go),
    .miss_tag    (bus_tag),
    .req_ready   (rd_req_ready),
    .fill_last   (fill_last),
    .req_valid   (rd_req_valid),
    .req_tag     (req_tag),
    .fill_active (fill_active),
    .fill_start  (fill_start),
    .idle        (fsm_idle)
  );
endmodule

// File: rtl/bpb_checker.sv
module bpb_checker #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_write,
  input logic [AW-1:0]          bus_addr,
  input logic                   bus_ready,
  input logic                   rd_req_valid,
  input logic                   rd_req_ready,
  input logic [AW-1:0]          rd_req_addr,
  input logic                   wr_req_valid,
  input logic                   wr_req_ready,
  input logic [AW-1:0]          wr_req_addr,
  input logic [WORDS*DW/8-1:0]  wr_req_be
);
  localparam int OFF_W = $clog2(WORDS) + $clog2(DW / 8);

  p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!rd_req_valid && !wr_req_valid));

  p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_req_addr[OFF_W-1:0] == '0));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  p_write_posted_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && !wr_req_valid) |-> bus_ready);

  p_write_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && wr_req_valid &&
     wr_req_addr[AW-1:OFF_W] != bus_addr[AW-1:OFF_W]) |-> !bus_ready);

  p_no_fetch_over_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !(wr_req_valid && wr_req_addr[AW-1:OFF_W] == rd_req_addr[AW-1:OFF_W]));

  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_valid && !wr_req_ready) |=>
      (wr_req_valid && $stable(wr_req_addr) && (($past(wr_req_be) & ~wr_req_be) == '0)));
endmodule

bind bus_port_buffer bpb_checker #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_bpb_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_valid    (bus_valid),
  .bus_write    (bus_write),
  .bus_addr     (bus_addr),
  .bus_ready    (bus_ready),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .wr_req_valid (wr_req_valid),
  .wr_req_ready (wr_req_ready),
  .wr_req_addr  (wr_req_addr),
  .wr_req_be    (wr_req_be)
);

// File: tb/bus_port_buffer_bench.sv
`timescale 1ns/1ps
module bus_port_buffer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0]  bus_addr = '0;
  logic [3:0]   bus_be = '0;
  logic [31:0]  bus_wdata = '0;
  logic         bus_ready;
  logic [31:0]  bus_rdata;
  logic         rd_req_valid, rd_req_ready = 1'b0;
  logic [31:0]  rd_req_addr;
  logic         rd_rsp_valid = 1'b0;
  logic [31:0]  rd_rsp_data = '0;
  logic         wr_req_valid, wr_req_ready = 1'b0;
  logic [31:0]  wr_req_addr;
  logic [255:0] wr_req_data;
  logic [31:0]  wr_req_be;

  bus_port_buffer u_bus_port_buffer (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // memory behind the scheduler and the value the bus should observe
  logic [31:0] mem [int];
  logic [31:0] vis [int];

  function automatic logic [31:0] seedw(int a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction
  function automatic logic [31:0] mem_rd(int a);
    return mem.exists(a) ? mem[a] : seedw(a);
  endfunction
  function automatic logic [31:0] vis_rd(int a);
    return vis.exists(a) ? vis[a] : seedw(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_line_valid, m_line_wr, m_just_filled, m_wb_valid, m_first;
  int          m_line_tag, m_wb_tag, m_req_tag, m_state, m_beats;
  logic [31:0]  m_wb_mask;
  logic [255:0] m_wb_data;
  int          rsp_q [$];

  always @(negedge clk) begin
    #5;
    if (!rst_n) begin
      m_line_valid = 0; m_line_wr = 0; m_just_filled = 0; m_wb_valid = 0;
      m_state = 0; m_beats = 0; m_wb_mask = '0; m_wb_data = '0; m_first = 1;
    end else begin
      int  tag, idx, wa;
      bit  is_rd, is_wr, hit, wbm, exp_rdy, drain, ok;
      string lbl;
      if (m_first) begin
        chk(!rd_req_valid, "R1 rd_req_valid", 256'(rd_req_valid), 0);
        chk(!wr_req_valid, "R1 wr_req_valid", 256'(wr_req_valid), 0);
        m_first = 0;
      end
      tag   = int'(bus_addr[31:5]);
      idx   = int'(bus_addr[4:2]);
      wa    = tag * 8 + idx;
      is_rd = bus_valid && !bus_write;
      is_wr = bus_valid && bus_write;
      hit   = m_line_valid && m_line_tag == tag;
      wbm   = m_wb_valid && m_wb_tag == tag;
      if (!bus_valid)  begin exp_rdy = 1; lbl = "idle ready"; end
      else if (is_wr)  begin exp_rdy = !m_wb_valid || wbm; lbl = exp_rdy ? "R5 write ready" : "R7 write stall"; end
      else             begin exp_rdy = hit; lbl = hit ? "R4 read hit" : (wbm ? "R9 read stall" : "R2 read miss"); end
      chk(bus_ready == exp_rdy, lbl, 256'(bus_ready), 256'(exp_rdy));
      if (is_rd && exp_rdy) begin
        lbl = m_line_wr ? "R8 patched data" : (m_just_filled ? "R3 filled data" : "R4 hit data");
        chk(bus_rdata == vis_rd(wa), lbl, 256'(bus_rdata), 256'(vis_rd(wa)));
        m_just_filled = 0;
      end
      chk(rd_req_valid == (m_state == 1), "R2 rd_req_valid", 256'(rd_req_valid), 256'(m_state == 1));
      if (rd_req_valid && m_state == 1)
        chk(rd_req_addr == {m_req_tag[26:0], 5'b0}, "R2 rd_req_addr", 256'(rd_req_addr), 256'({m_req_tag[26:0], 5'b0}));
      chk(wr_req_valid == m_wb_valid, "R10 wr_req_valid", 256'(wr_req_valid), 256'(m_wb_valid));
      if (wr_req_valid && m_wb_valid) begin
        chk(wr_req_addr == {m_wb_tag[26:0], 5'b0}, "R10 wr_req_addr", 256'(wr_req_addr), 256'({m_wb_tag[26:0], 5'b0}));
        chk(wr_req_be == m_wb_mask, "R6 wr_req_be", 256'(wr_req_be), 256'(m_wb_mask));
        ok = 1;
        for (int i = 0; i < 32; i++)
          if (m_wb_mask[i] && wr_req_data[8*i +: 8] != m_wb_data[8*i +: 8]) ok = 0;
        chk(ok, "R6 wr_req_data", wr_req_data, m_wb_data);
      end
      // advance model to the next clock edge
      drain = m_wb_valid && wr_req_ready;
      if (drain) begin
        for (int w = 0; w < 8; w++) begin
          logic [31:0] v;
          v = mem_rd(m_wb_tag * 8 + w);
          for (int b = 0; b < 4; b++)
            if (m_wb_mask[w*4 + b]) v[8*b +: 8] = m_wb_data[32*w + 8*b +: 8];
          mem[m_wb_tag * 8 + w] = v;
        end
        m_wb_mask = '0;
      end
      if (is_wr && exp_rdy) begin
        logic [31:0] v;
        v = vis_rd(wa);
        for (int b = 0; b < 4; b++)
          if (bus_be[b]) begin
            v[8*b +: 8] = bus_wdata[8*b +: 8];
            m_wb_mask[idx*4 + b] = 1'b1;
            m_wb_data[32*idx + 8*b +: 8] = bus_wdata[8*b +: 8];
          end
        vis[wa] = v;
        if (hit) m_line_wr = 1;
        m_wb_tag = tag;
        m_wb_valid = 1;
      end else if (drain) begin
        m_wb_valid = 0;
      end
      case (m_state)
        0: if (is_rd && !hit && !wbm) begin m_state = 1; m_req_tag = tag; end
        1: if (rd_req_ready) begin
             m_state = 2; m_line_valid = 0; m_line_tag = m_req_tag; m_beats = 0;
             rsp_q.push_back(m_req_tag);
           end
        default: if (rd_rsp_valid) begin
             m_beats++;
             if (m_beats == 8) begin
               m_state = 0; m_line_valid = 1; m_line_wr = 0; m_just_filled = 1;
             end
           end
      endcase
    end
  end

  // ---------------- scheduler side ----------------
  int rsp_k = 0;
  always @(negedge clk) begin
    rd_req_ready <= (cyc % 3) != 0;
    wr_req_ready <= (cyc % 7) >= 4;
    if (rst_n && rsp_q.size() > 0 && (cyc % 4) != 2) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= mem_rd(rsp_q[0] * 8 + rsp_k);
      if (rsp_k == 7) begin rsp_k = 0; void'(rsp_q.pop_front()); end
      else rsp_k++;
    end else begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- bus master ----------------
  task automatic op(input bit w, input int tag, input int idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w;
    bus_addr  = {tag[26:0], idx[2:0], 2'b00};
    bus_be    = be; bus_wdata = d;
    #6;
    while (!bus_ready) begin @(negedge clk); #6; end
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  localparam int T0 = 32'h100, T1 = 32'h101, T2 = 32'h102;
  logic [31:0] lf = 32'hACE1_1234;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();
    op(0, T0, 2, 4'h0, 0);              // R2/R3 miss then fill
    op(0, T0, 5, 4'h0, 0);              // R4 hit
    op(1, T0, 5, 4'b0011, 32'h1111_2222); // R5, R8 patch
    op(0, T0, 5, 4'h0, 0);              // R8
    op(1, T0, 6, 4'hF, 32'hDEAD_BEEF);
    op(1, T0, 6, 4'b1000, 32'h7700_0000); // R6 merge
    op(1, T1, 0, 4'hF, 32'h0BAD_F00D);  // R7 stall
    op(0, T1, 0, 4'h0, 0);              // R9 stall then fetch
    op(0, T1, 3, 4'h0, 0);
    op(0, T2, 1, 4'h0, 0);
    op(0, T0, 6, 4'h0, 0);              // R3 refetch shows drained data
    for (int n = 0; n < 600; n++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[2:0] == 3'd0) idle();
      else op(lf[3], T0 + int'(lf[5:4]), int'(lf[8:6]),
              (lf[12:9] == 4'h0) ? 4'h1 : lf[12:9], lf ^ 32'h3C3C_5A5A);
    end
    idle();
    repeat (40) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule